// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the programmer side of a four-wire serial programming link. It drives the target's serial clock, data-out and reset lines and reads the target's data-in line. After its own reset it holds the target reset and the serial clock low. It then gives the target reset a short high pulse and waits a programmable settling time. Next it shifts out the 32-bit programming-enable instruction. The byte that comes back while the third instruction byte is sent must be 0x53. If it is not, the sequencer still finishes the whole instruction, pulses the target reset again and repeats the enable. When a set number of attempts has failed, it stops and reports a sticky error.

Once the link is synchronised, a host issues 32-bit instructions through a valid/ready port. The sequencer shifts each instruction out most significant bit first, byte one first. It returns the fourth byte it received, together with a one-cycle done strobe. The length of each serial clock phase is a whole number of target clock periods. That number is chosen at the start of each transfer from a speed-mode input, so the target's minimum phase rule holds in both speed ranges.

Top module: `isp_host_seq`

## Requirements
- R1: After `rstN` is released, `tgtReset` and `tgtSck` are low and `cmdReady`, `inSync`, `syncError` and `respDone` are low. `tgtReset` stays low for at least 3*TGT_DIV cycles. It then goes high for exactly 3*TGT_DIV host cycles, and `tgtSck` is low whenever `tgtReset` is high.
- R2: Between the falling edge of a `tgtReset` pulse and the next rising edge of `tgtSck` there are at least WAIT_CYCLES host cycles.
- R3: The enable instruction is the word 0xAC530000. It is sent most significant bit first, so byte one (0xAC) goes first. `tgtMosi` does not change while `tgtSck` is high.
- R4: An enable instruction is always sent in full, all 32 clock pulses, even when its echo is wrong.
- R5: The echo is bits 15:8 of the received word, that is the byte received during byte three. If the echo equals 0x53, `inSync` rises. Otherwise `tgtReset` is pulsed again and a new enable instruction is sent.
- R6: During a transfer, every low and every high phase of `tgtSck` lasts 3*TGT_DIV host cycles when `speedFast` is 0, and 4*TGT_DIV host cycles when it is 1. `speedFast` is sampled only when a transfer starts.
- R7: `tgtMiso` is sampled at the host clock edge where `tgtSck` falls. Received bits fill the word from bit 31 down to bit 0.
- R8: After MAX_TRIES enable attempts that all have a wrong echo, `syncError` goes high and stays high until `rstN`. No further serial clock pulses follow, and `inSync` stays low.
- R9: `cmdReady` is high only while in sync with no transfer running. A command taken on `cmdValid && cmdReady` sends `cmdData` MSB first and drops `cmdReady` until the transfer ends.
- R10: At the end of a command, `respDone` is high for exactly one cycle, with `respData` equal to bits 7:0 of the received word. `cmdReady` is high in that same cycle, so a new command can be taken at once.
- R11: `cmdValid` has no effect before sync is reached: it causes no serial clock pulse and no `respDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedFast | input | 1 | 1 selects the longer clock phases for a fast target |
| cmdValid | input | 1 | Host offers a command |
| cmdReady | output | 1 | Sequencer can take a command |
| cmdData | input | 32 | Command word, byte one in bits 31:24 |
| respDone | output | 1 | One-cycle strobe at the end of a command |
| respData | output | 8 | Fourth received byte of the last command |
| inSync | output | 1 | Enable echo matched; link usable |
| syncError | output | 1 | Sticky: retry limit reached |
| tgtSck | output | 1 | Serial clock to the target |
| tgtMosi | output | 1 | Serial data to the target |
| tgtMiso | input | 1 | Serial data from the target |
| tgtReset | output | 1 | Target reset line, high during a reset pulse |

## Verification
Two functions can fall in the same cycle: reporting a finished command on `respDone`/`respData`, and accepting the next command, because `cmdReady` is already high in the strobe cycle. The bench provokes this by keeping `cmdValid` high from the first command through to its completion, with a second word already on `cmdData`. It judges the result three ways: the first response must be intact in the strobe cycle, `cmdReady` must drop one cycle later, and the target model must receive the second word and return its own response byte. The echo decision and the retry reset pulse also meet at the end of a failed enable. The bench forces failed echoes and counts the complete frames and reset pulses.

// File: rtl/isp_host_pkg.sv
package isp_host_pkg;

  localparam logic [31:0] ENABLE_WORD = 32'hAC53_0000;
  localparam logic [7:0]  ECHO_BYTE   = 8'h53;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEnable;
    logic loadCmd;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_SETTLE,
    S_PULSE,
    S_WAIT,
    S_ENABLE,
    S_READY,
    S_CMD,
    S_FAIL
  } seqState_t;

endpackage

// File: rtl/isp_host_dp.sv
module isp_host_dp
  import isp_host_pkg::*;
#(
  parameter int TGT_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [31:0] cmdData,
  input  logic        speedFast,
  input  logic        tgtMiso,
  output logic        tgtSck,
  output logic        tgtMosi,
  output logic        xferDone,
  output logic [15:0] rxTail
);

  localparam int SLOW_PHASE = 3 * TGT_DIV;
  localparam int FAST_PHASE = 4 * TGT_DIV;
  localparam int PH_W       = $clog2(FAST_PHASE + 1);

  logic            busy;
  logic            sckQ;
  logic            fastQ;
  logic [PH_W-1:0] phCnt;
  logic [4:0]      bitCnt;
  logic [31:0]     shReg;
  logic            doneQ;
  logic            phLast;

  assign phLast = fastQ ? (phCnt == PH_W'(FAST_PHASE - 1))
                        : (phCnt == PH_W'(SLOW_PHASE - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sckQ   <= 1'b0;
      fastQ  <= 1'b0;
      phCnt  <= '0;
      bitCnt <= '0;
      shReg  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!busy) begin
        if (ctl.loadEnable || ctl.loadCmd) begin
          busy   <= 1'b1;
          shReg  <= ctl.loadEnable ? ENABLE_WORD : cmdData;
          fastQ  <= speedFast;
          phCnt  <= '0;
          bitCnt <= '0;
          sckQ   <= 1'b0;
        end
      end else if (phLast) begin
        phCnt <= '0;
        if (!sckQ) begin
          sckQ <= 1'b1;
        end else begin
          sckQ   <= 1'b0;
          shReg  <= {shReg[30:0], tgtMiso};
          bitCnt <= bitCnt + 5'd1;
          if (bitCnt == 5'd31) begin
            busy  <= 1'b0;
            doneQ <= 1'b1;
          end
        end
      end else begin
        phCnt <= phCnt + 1'b1;
      end
    end
  end

  assign tgtSck   = sckQ;
  assign tgtMosi  = busy & shReg[31];
  assign xferDone = doneQ;
  assign rxTail   = shReg[15:0];

endmodule

// File: rtl/isp_host_ctrl.sv
module isp_host_ctrl
  import isp_host_pkg::*;
#(
  parameter int TGT_DIV     = 2,
  parameter int WAIT_CYCLES = 320000,
  parameter int MAX_TRIES   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic        xferDone,
  input  logic [15:0] rxTail,
  output dpCtl_t      ctl,
  output logic        tgtReset,
  output logic        inSync,
  output logic        syncError,
  output logic        respDone,
  output logic [7:0]  respData
);

  localparam int PULSE_LEN = 3 * TGT_DIV;
  localparam int TMR_MAX   = (WAIT_CYCLES > PULSE_LEN) ? WAIT_CYCLES : PULSE_LEN;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);

  seqState_t        state;
  logic [TMR_W-1:0] tmr;
  logic [TRY_W-1:0] tries;
  logic             respDoneQ;
  logic [7:0]       respDataQ;
  logic             pulseHit;
  logic             waitHit;
  logic             echoOk;

  assign pulseHit = (tmr == TMR_W'(PULSE_LEN - 1));
  assign waitHit  = (tmr == TMR_W'(WAIT_CYCLES - 1));
  assign echoOk   = (rxTail[15:8] == ECHO_BYTE);

  assign ctl.loadEnable = (state == S_WAIT) && waitHit;
  assign ctl.loadCmd    = (state == S_READY) && cmdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_SETTLE;
      tmr       <= '0;
      tries     <= '0;
      respDoneQ <= 1'b0;
      respDataQ <= '0;
    end else begin
      respDoneQ <= 1'b0;
      case (state)
        S_SETTLE: begin
          if (pulseHit) begin
            state <= S_PULSE;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_PULSE: begin
          if (pulseHit) begin
            state <= S_WAIT;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_WAIT: begin
          if (waitHit) begin
            state <= S_ENABLE;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_ENABLE: begin
          if (xferDone) begin
            if (echoOk) begin
              state <= S_READY;
              tries <= '0;
            end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
              state <= S_FAIL;
            end else begin
              tries <= tries + 1'b1;
              state <= S_PULSE;
              tmr   <= '0;
            end
          end
        end
        S_READY: begin
          if (cmdValid) state <= S_CMD;
        end
        S_CMD: begin
          if (xferDone) begin
            respDoneQ <= 1'b1;
            respDataQ <= rxTail[7:0];
            state     <= S_READY;
          end
        end
        S_FAIL:  state <= S_FAIL;
        default: state <= S_FAIL;
      endcase
    end
  end

  assign tgtReset  = (state == S_PULSE);
  assign inSync    = (state == S_READY) || (state == S_CMD);
  assign cmdReady  = (state == S_READY);
  assign syncError = (state == S_FAIL);
  assign respDone  = respDoneQ;
  assign respData  = respDataQ;

endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
  import isp_host_pkg::*;
#(
  parameter int TGT_DIV     = 2,
  parameter int WAIT_CYCLES = 320000,
  parameter int MAX_TRIES   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        speedFast,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic [31:0] cmdData,
  output logic        respDone,
  output logic [7:0]  respData,
  output logic        inSync,
  output logic        syncError,
  output logic        tgtSck,
  output logic        tgtMosi,
  input  logic        tgtMiso,
  output logic        tgtReset
);

  dpCtl_t      dpCtl;
  logic        xferDone;
  logic [15:0] rxTail;

  isp_host_ctrl #(
    .TGT_DIV    (TGT_DIV),
    .WAIT_CYCLES(WAIT_CYCLES),
    .MAX_TRIES  (MAX_TRIES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdReady (cmdReady),
    .xferDone (xferDone),
    .rxTail   (rxTail),
    .ctl      (dpCtl),
    .tgtReset (tgtReset),
    .inSync   (inSync),
    .syncError(syncError),
    .respDone (respDone),
    .respData (respData)
  );

  isp_host_dp #(
    .TGT_DIV(TGT_DIV)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (dpCtl),
    .cmdData  (cmdData),
    .speedFast(speedFast),
    .tgtMiso  (tgtMiso),
    .tgtSck   (tgtSck),
    .tgtMosi  (tgtMosi),
    .xferDone (xferDone),
    .rxTail   (rxTail)
  );

endmodule

// File: rtl/isp_host_seq_chk.sv
module isp_host_seq_chk #(
  parameter int TGT_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic respDone,
  input logic inSync,
  input logic syncError,
  input logic tgtSck,
  input logic tgtMosi,
  input logic tgtReset
);

  localparam int MINPH = 3 * TGT_DIV;
  localparam int RW    = $clog2(4 * TGT_DIV + 1) + 1;

  logic          prevSck;
  logic [RW-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSck <= 1'b0;
      runLen  <= '0;
    end else begin
      prevSck <= tgtSck;
      if (tgtSck != prevSck) runLen <= RW'(1);
      else if (runLen != {RW{1'b1}}) runLen <= runLen + 1'b1;
    end
  end

  // R1
  rst_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtReset |-> !tgtSck);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSck && $past(tgtSck)) |-> $stable(tgtMosi));

  // R6
  phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSck != prevSck) |-> (runLen >= RW'(MINPH)));

  // R8
  sync_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncError |=> syncError);

  // R8
  sync_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncError |-> !inSync);

  // R9
  ready_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> inSync);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);

  // R11
  nosync_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inSync |-> !respDone);

endmodule

bind isp_host_seq isp_host_seq_chk #(.TGT_DIV(TGT_DIV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .respDone (respDone),
  .inSync   (inSync),
  .syncError(syncError),
  .tgtSck   (tgtSck),
  .tgtMosi  (tgtMosi),
  .tgtReset (tgtReset)
);

// File: tb/isp_host_seq_tb.sv
module isp_host_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TGT_DIV    = 2;
  localparam int WAIT_CYC   = 50;
  localparam int MAX_TRY    = 3;
  localparam int SLOW_PH    = 3 * TGT_DIV;
  localparam int FAST_PH    = 4 * TGT_DIV;
  localparam int PULSE      = 3 * TGT_DIV;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        speedFast = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [31:0] cmdData = '0;
  logic        respDone;
  logic [7:0]  respData;
  logic        inSync;
  logic        syncError;
  logic        tgtSck;
  logic        tgtMosi;
  logic        tgtMiso = 1'b0;
  logic        tgtReset;

  int checks = 0;
  int errors = 0;

  isp_host_seq #(
    .TGT_DIV    (TGT_DIV),
    .WAIT_CYCLES(WAIT_CYC),
    .MAX_TRIES  (MAX_TRY)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .speedFast(speedFast),
    .cmdValid (cmdValid),
    .cmdReady (cmdReady),
    .cmdData  (cmdData),
    .respDone (respDone),
    .respData (respData),
    .inSync   (inSync),
    .syncError(syncError),
    .tgtSck   (tgtSck),
    .tgtMosi  (tgtMosi),
    .tgtMiso  (tgtMiso),
    .tgtReset (tgtReset)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // target model and line monitor
  int          bitIdx = 0;
  logic [31:0] rxShift = '0;
  logic [31:0] lastFrame = '0;
  logic [31:0] respWord = '0;
  int          frames = 0;
  int          badLeft = 0;
  int          pulses = 0;
  int          pulseRun = 0;
  int          pulseLen = 0;
  int          sinceFall = 0;
  bit          gapOpen = 0;
  int          firstGap = -1;
  int          sckRun = 0;
  int          lastLow = 0;
  int          lastHigh = 0;
  int          rises = 0;
  int          doneCount = 0;
  bit          prevSck = 0;
  bit          prevRst = 0;

  always @(negedge clk) begin
    if (!rstN || tgtReset) bitIdx = 0;
    if (respDone) doneCount++;
    if (tgtReset && !prevRst) begin
      pulses++;
      pulseRun = 0;
    end
    if (tgtReset) pulseRun++;
    if (!tgtReset && prevRst) begin
      pulseLen  = pulseRun;
      sinceFall = 1;
      gapOpen   = 1;
    end else if (gapOpen) sinceFall++;
    if (tgtSck != prevSck) begin
      if (tgtSck) begin
        rises++;
        if (bitIdx > 0) lastLow = sckRun;
        if (gapOpen) begin
          firstGap = sinceFall;
          gapOpen  = 0;
        end
        if (bitIdx == 0)
          respWord = {16'h0000, (badLeft > 0) ? 8'h35 : 8'h53, 8'h5A + frames[7:0]};
        rxShift = {rxShift[30:0], tgtMosi};
        tgtMiso = respWord[31 - bitIdx];
        bitIdx++;
        if (bitIdx == 32) begin
          bitIdx    = 0;
          lastFrame = rxShift;
          frames++;
          if (badLeft > 0) badLeft--;
        end
      end else begin
        lastHigh = sckRun;
      end
      sckRun = 1;
    end else sckRun++;
    prevSck = tgtSck;
    prevRst = tgtReset;
  end

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkGe(input string req, input string what,
                       input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
    end
  endtask

  task automatic doReset(input int bad);
    rstN      = 1'b0;
    cmdValid  = 1'b0;
    speedFast = 1'b0;
    repeat (3) tick();
    badLeft   = bad;
    frames    = 0;
    pulses    = 0;
    rises     = 0;
    doneCount = 0;
    firstGap  = -1;
    gapOpen   = 0;
    rstN      = 1'b1;
  endtask

  task automatic waitSettled(input int limit);
    for (int n = 0; n < limit && !inSync && !syncError; n++) tick();
  endtask

  task automatic sendCmd(input logic [31:0] word, input bit dropFast,
                         output logic [7:0] got);
    for (int n = 0; n < 200 && !cmdReady; n++) tick();
    cmdData  = word;
    cmdValid = 1'b1;
    tick();
    chkEq("R9", "cmdReady after accept", {31'd0, cmdReady}, 32'd0);
    cmdValid = 1'b0;
    if (dropFast) speedFast = 1'b0;
    for (int n = 0; n < 3000 && !respDone; n++) tick();
    got = respData;
    chkEq("R10", "respDone seen", {31'd0, respDone}, 32'd1);
    tick();
    chkEq("R10", "respDone one cycle", {31'd0, respDone}, 32'd0);
  endtask

  task automatic t_resetState;
    int n;
    doReset(0);
    tick();
    chkEq("R1", "tgtSck after reset", {31'd0, tgtSck}, 32'd0);
    chkEq("R1", "tgtReset after reset", {31'd0, tgtReset}, 32'd0);
    chkEq("R1", "flags after reset",
          {27'd0, cmdReady, inSync, syncError, respDone, 1'b0}, 32'd0);
    n = 1;
    while (!tgtReset && n < 100) begin
      tick();
      n++;
    end
    chkGe("R1", "low time before pulse", n, PULSE);
  endtask

  task automatic t_bringUp;
    cmdData  = 32'hDEAD_BEEF;
    cmdValid = 1'b1;
    for (int n = 0; n < 20; n++) begin
      tick();
      if (cmdReady) chkEq("R11", "cmdReady before sync", 32'd1, 32'd0);
    end
    cmdValid = 1'b0;
    chkEq("R11", "no clock pulses from early cmdValid", rises, 0);
    waitSettled(3000);
    chkEq("R5", "inSync", {31'd0, inSync}, 32'd1);
    chkEq("R1", "reset pulse count", pulses, 1);
    chkEq("R1", "reset pulse width", pulseLen, PULSE);
    chkGe("R2", "gap after reset pulse", firstGap, WAIT_CYC);
    chkEq("R3", "enable frame", lastFrame, 32'hAC53_0000);
    chkEq("R11", "frames before sync", frames, 1);
    chkEq("R11", "no response before sync", doneCount, 0);
  endtask

  task automatic t_slowCmd;
    logic [7:0] got;
    logic [7:0] exp;
    exp = 8'h5A + frames[7:0];
    speedFast = 1'b0;
    sendCmd(32'h4C00_0700, 1'b0, got);
    chkEq("R7", "slow response byte", {24'd0, got}, {24'd0, exp});
    chkEq("R9", "slow command on wire", lastFrame, 32'h4C00_0700);
    chkEq("R6", "slow high phase", lastHigh, SLOW_PH);
    chkEq("R6", "slow low phase", lastLow, SLOW_PH);
  endtask

  task automatic t_fastCmd;
    logic [7:0] got;
    logic [7:0] exp;
    exp = 8'h5A + frames[7:0];
    speedFast = 1'b1;
    sendCmd(32'h2013_A5C3, 1'b1, got);
    chkEq("R7", "fast response byte", {24'd0, got}, {24'd0, exp});
    chkEq("R9", "fast command on wire", lastFrame, 32'h2013_A5C3);
    chkEq("R6", "fast high phase, speed latched", lastHigh, FAST_PH);
    chkEq("R6", "fast low phase, speed latched", lastLow, FAST_PH);
  endtask

  task automatic t_backToBack;
    logic [7:0] expA;
    logic [7:0] expB;
    expA = 8'h5A + frames[7:0];
    expB = expA + 8'd1;
    for (int n = 0; n < 200 && !cmdReady; n++) tick();
    cmdData  = 32'h1111_2222;
    cmdValid = 1'b1;
    tick();
    cmdData = 32'h9876_5432;
    for (int n = 0; n < 3000 && !respDone; n++) tick();
    chkEq("R10", "first response in strobe cycle", {24'd0, respData}, {24'd0, expA});
    chkEq("R10", "cmdReady in strobe cycle", {31'd0, cmdReady}, 32'd1);
    tick();
    chkEq("R10", "second command taken", {31'd0, cmdReady}, 32'd0);
    cmdValid = 1'b0;
    for (int n = 0; n < 3000 && !respDone; n++) tick();
    chkEq("R10", "second response", {24'd0, respData}, {24'd0, expB});
    chkEq("R9", "second command on wire", lastFrame, 32'h9876_5432);
  endtask

  task automatic t_retry;
    doReset(1);
    waitSettled(5000);
    chkEq("R5", "inSync after one retry", {31'd0, inSync}, 32'd1);
    chkEq("R4", "complete enable frames", frames, 2);
    chkEq("R5", "reset pulses with retry", pulses, 2);
    chkEq("R5", "retried enable frame", lastFrame, 32'hAC53_0000);
    chkEq("R8", "no error after retry", {31'd0, syncError}, 32'd0);
  endtask

  task automatic t_fail;
    int risesAt;
    doReset(10);
    waitSettled(8000);
    chkEq("R8", "syncError raised", {31'd0, syncError}, 32'd1);
    chkEq("R8", "attempt frames", frames, MAX_TRY);
    chkEq("R8", "reset pulses", pulses, MAX_TRY);
    chkEq("R8", "inSync low", {31'd0, inSync}, 32'd0);
    risesAt  = rises;
    cmdData  = 32'h5555_AAAA;
    cmdValid = 1'b1;
    for (int n = 0; n < 500; n++) tick();
    cmdValid = 1'b0;
    chkEq("R8", "syncError sticky", {31'd0, syncError}, 32'd1);
    chkEq("R11", "no clock after failure", rises, risesAt);
    chkEq("R11", "no response after failure", doneCount, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_resetState();
    t_bringUp();
    t_slowCmd();
    t_fastCmd();
    t_backToBack();
    t_retry();
    t_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule